// File: doc/BRIEF.md
# Event-Capturing GPIO Port Controller

This block is a parameterised general-purpose I/O port of up to 32 pins behind a simple word-wide register bus. The bus has an address, a write strobe, a full-word qualifier, write data and combinational read data. Software uses six registers to pick each pin's direction, to hold an open-drain setting, to read and write pin data, to arm interrupts, and to choose the edge policy for each pin. Each output-direction pin drives the bit last written to it. Each input-direction pin is sampled into the data register.

A change on an input pin sets that pin's event bit. The pin's control bit selects one of two policies. With the control bit at 0, a change in either direction sets the event. With the control bit at 1, only a high-to-low transition sets it. Software clears event bits by writing ones to them. A single level interrupt is high while any event bit is set whose mask bit is also set. Pin numbering is reversed with respect to register bits, so pin 0 sits in the most significant bit of every register.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset, all six registers read zero, every `pin_out` bit is 0 and `irq` is 0.
- R2: The registers sit at these byte offsets: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, control 0x14. Direction, open-drain, mask and control read back the last word written to them. Any other offset reads zero, and writes to it change nothing.
- R3: An access with `bus_word` low has no effect. A write with `bus_word` low is dropped, and `bus_rdata` is zero while `bus_word` is low.
- R4: Pin i corresponds to register bit (31 − i). The pin is carried on `pin_in[i]` and `pin_out[i]`.
- R5: A full-word data write stores the written word. A data write in the same cycle overrides that cycle's sample. Only pins whose direction bit is 1 (output) load their new bit onto `pin_out`. `pin_out` keeps its value in every cycle without a data write.
- R6: A write to the event register clears each event bit where the written word holds a 1. Bits written as 0 keep their value.
- R7: For an input pin (direction bit 0), the level on `pin_in` reaches the data register two clock edges after it is applied. For an output pin, `pin_in` is ignored and the data bit keeps its value.
- R8: For an input pin whose control bit is 0, any difference between the new sample and the stored data bit sets its event bit. For an input pin whose control bit is 1, only a stored 1 replaced by a sampled 0 sets it.
- R9: `irq` is 1 exactly when some bit is set in both the event and the mask registers, and it follows every register write and input change in the same clock edge that updates those registers.
- R10: When an input change sets an event bit in the same edge in which software writes a 1 to clear that bit, the bit ends up set.
- R11: The open-drain register is storage only. Writing it leaves `pin_out` and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_word | input | 1 | High for a full 32-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | NPINS | Input levels, bit i is pin i |
| pin_out | output | NPINS | Driven output levels, bit i is pin i |
| irq | output | 1 | Level interrupt, registered |

## Verification
The bench builds the block with its defaults: 32 pins and a 12-bit offset. With these values pin 0 lands on bit 31 and pin 31 lands on bit 0, so both ends of the reversed mapping are exercised. The 12-bit offset also leaves room for unmapped offsets such as 0x18, which show that stray writes have no effect. Because all 32 pins are present, a full-word data write reaches a mix of input and output pins at once. That shows the per-pin split between driving an output and resampling an input.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int BUS_DW = 32;

  localparam int OFS_DIR = 'h00;
  localparam int OFS_ODR = 'h04;
  localparam int OFS_DAT = 'h08;
  localparam int OFS_EVT = 'h0C;
  localparam int OFS_MSK = 'h10;
  localparam int OFS_CTL = 'h14;

  typedef enum logic [2:0] {
    RS_DIR,
    RS_ODR,
    RS_DAT,
    RS_EVT,
    RS_MSK,
    RS_CTL,
    RS_NONE
  } reg_sel_e;

  typedef struct packed {
    logic dir;
    logic odr;
    logic dat;
    logic evt;
    logic msk;
    logic ctl;
  } wr_stb_t;

endpackage

// File: rtl/gpio_evt_decode.sv
module gpio_evt_decode
  import gpio_evt_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [BUS_DW-1:0] dir_w,
  input  logic [BUS_DW-1:0] odr_w,
  input  logic [BUS_DW-1:0] dat_w,
  input  logic [BUS_DW-1:0] evt_w,
  input  logic [BUS_DW-1:0] msk_w,
  input  logic [BUS_DW-1:0] ctl_w,
  output wr_stb_t           stb,
  output logic [BUS_DW-1:0] rdata
);

  reg_sel_e sel;

  always_comb begin
    sel = RS_NONE;
    if (bus_addr == AW'(OFS_DIR)) sel = RS_DIR;
    else if (bus_addr == AW'(OFS_ODR)) sel = RS_ODR;
    else if (bus_addr == AW'(OFS_DAT)) sel = RS_DAT;
    else if (bus_addr == AW'(OFS_EVT)) sel = RS_EVT;
    else if (bus_addr == AW'(OFS_MSK)) sel = RS_MSK;
    else if (bus_addr == AW'(OFS_CTL)) sel = RS_CTL;
  end

  always_comb begin
    stb = '0;
    if (bus_we && bus_word) begin
      case (sel)
        RS_DIR:  stb.dir = 1'b1;
        RS_ODR:  stb.odr = 1'b1;
        RS_DAT:  stb.dat = 1'b1;
        RS_EVT:  stb.evt = 1'b1;
        RS_MSK:  stb.msk = 1'b1;
        RS_CTL:  stb.ctl = 1'b1;
        default: stb = '0;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (bus_word) begin
      case (sel)
        RS_DIR:  rdata = dir_w;
        RS_ODR:  rdata = odr_w;
        RS_DAT:  rdata = dat_w;
        RS_EVT:  rdata = evt_w;
        RS_MSK:  rdata = msk_w;
        RS_CTL:  rdata = ctl_w;
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_evt_pin.sv
module gpio_evt_pin
  import gpio_evt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  wr_stb_t stb,
  input  logic    wbit,
  input  logic    smp,
  output logic    dir_o,
  output logic    odr_o,
  output logic    dat_o,
  output logic    evt_o,
  output logic    msk_o,
  output logic    ctl_o,
  output logic    pout_o,
  output logic    irq_term_nxt
);

  logic dir_q, odr_q, dat_q, evt_q, msk_q, ctl_q, pout_q;
  logic dir_d, odr_d, dat_d, evt_d, msk_d, ctl_d, pout_d;
  logic hit;

  // A sample differing from the stored bit is an edge; falling-only when ctl is set.
  assign hit = !dir_q && !stb.dat && (smp != dat_q) && (!ctl_q || dat_q);

  always_comb begin
    dir_d  = stb.dir ? wbit : dir_q;
    odr_d  = stb.odr ? wbit : odr_q;
    msk_d  = stb.msk ? wbit : msk_q;
    ctl_d  = stb.ctl ? wbit : ctl_q;
    dat_d  = dat_q;
    if (stb.dat)     dat_d = wbit;
    else if (!dir_q) dat_d = smp;
    evt_d  = evt_q;
    if (hit)                    evt_d = 1'b1;
    else if (stb.evt && wbit)   evt_d = 1'b0;
    pout_d = (stb.dat && dir_q) ? wbit : pout_q;
  end

  assign irq_term_nxt = evt_d & msk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b0;
      odr_q  <= 1'b0;
      dat_q  <= 1'b0;
      evt_q  <= 1'b0;
      msk_q  <= 1'b0;
      ctl_q  <= 1'b0;
      pout_q <= 1'b0;
    end else begin
      dir_q  <= dir_d;
      odr_q  <= odr_d;
      dat_q  <= dat_d;
      evt_q  <= evt_d;
      msk_q  <= msk_d;
      ctl_q  <= ctl_d;
      pout_q <= pout_d;
    end
  end

  assign dir_o  = dir_q;
  assign odr_o  = odr_q;
  assign dat_o  = dat_q;
  assign evt_o  = evt_q;
  assign msk_o  = msk_q;
  assign ctl_o  = ctl_q;
  assign pout_o = pout_q;

  a_r5_out_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(stb.dat) |-> $stable(pout_q));

  a_r7_out_pin_ignores_input: assert property (@(posedge clk) disable iff (rst)
    ($past(dir_q) && !$past(stb.dat)) |-> $stable(dat_q));

  a_r8_rise_no_event: assert property (@(posedge clk) disable iff (rst)
    $past(!dir_q && ctl_q && !dat_q && smp && !evt_q && !stb.dat) |-> !evt_q);

  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    $past(stb.evt && wbit && !hit) |-> !evt_q);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    $past(hit) |-> evt_q);

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic              irq
);

  localparam int SPARE = BUS_DW - NPINS;

  logic [NPINS-1:0]  in_q;
  logic [BUS_DW-1:0] dir_w, odr_w, dat_w, evt_w, msk_w, ctl_w;
  logic [NPINS-1:0]  irq_terms;
  logic              irq_q;
  wr_stb_t           stb;

  initial begin
    if (NPINS < 1 || NPINS > BUS_DW) $error("NPINS must lie in 1..32");
  end

  always_ff @(posedge clk) begin
    if (rst) in_q <= '0;
    else     in_q <= pin_in;
  end

  gpio_evt_decode #(.AW(AW)) u_dec (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_word (bus_word),
    .dir_w    (dir_w),
    .odr_w    (odr_w),
    .dat_w    (dat_w),
    .evt_w    (evt_w),
    .msk_w    (msk_w),
    .ctl_w    (ctl_w),
    .stb      (stb),
    .rdata    (bus_rdata)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int B = BUS_DW - 1 - i;
    gpio_evt_pin u_pin (
      .clk          (clk),
      .rst          (rst),
      .stb          (stb),
      .wbit         (bus_wdata[B]),
      .smp          (in_q[i]),
      .dir_o        (dir_w[B]),
      .odr_o        (odr_w[B]),
      .dat_o        (dat_w[B]),
      .evt_o        (evt_w[B]),
      .msk_o        (msk_w[B]),
      .ctl_o        (ctl_w[B]),
      .pout_o       (pin_out[i]),
      .irq_term_nxt (irq_terms[i])
    );
  end

  for (genvar j = 0; j < SPARE; j++) begin : g_spare
    assign dir_w[j] = 1'b0;
    assign odr_w[j] = 1'b0;
    assign dat_w[j] = 1'b0;
    assign evt_w[j] = 1'b0;
    assign msk_w[j] = 1'b0;
    assign ctl_w[j] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |irq_terms;
  end

  assign irq = irq_q;

  a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == |(evt_w & msk_w));

  a_r3_narrow_read_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_word |-> (bus_rdata == '0));

  a_r11_odr_no_pin_effect: assert property (@(posedge clk) disable iff (rst)
    ($past(stb.odr) && !$past(stb.dat)) |-> $stable(pin_out));

endmodule

// File: tb/sim_gpio_evt_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_evt_ctrl;

  localparam int NP = 32;
  localparam int AWB = 12;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [AWB-1:0] bus_addr = '0;
  logic           bus_we = 1'b0;
  logic           bus_word = 1'b1;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NP-1:0]  pin_in = '0;
  logic [NP-1:0]  pin_out;
  logic           irq;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  gpio_evt_ctrl #(.NPINS(NP), .AW(AWB)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic word = 1'b1);
    bus_addr = a; bus_wdata = d; bus_word = word; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_word = 1'b1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic word = 1'b1);
    bus_addr = a; bus_word = word; bus_we = 1'b0;
    #1 d = bus_rdata;
    bus_word = 1'b1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int k = 0; k < 6; k++) begin
      rd(12'(k*4), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset pin_out", pin_out, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(12'h000, 32'h1234_5678); rd(12'h000, v); chk("R2 dir readback", v, 32'h1234_5678);
    wr(12'h004, 32'hA5A5_0F0F); rd(12'h004, v); chk("R2 odr readback", v, 32'hA5A5_0F0F);
    chk("R11 odr no pin effect", pin_out, 32'h0);
    chk("R11 odr no irq effect", {31'b0, irq}, 32'h0);
    wr(12'h010, 32'h0F0F_0000); rd(12'h010, v); chk("R2 msk readback", v, 32'h0F0F_0000);
    wr(12'h014, 32'h00FF_00FF); rd(12'h014, v); chk("R2 ctl readback", v, 32'h00FF_00FF);
    wr(12'h018, 32'hFFFF_FFFF); rd(12'h018, v); chk("R2 unmapped reads zero", v, 32'h0);
    rd(12'h010, v); chk("R2 unmapped write ignored", v, 32'h0F0F_0000);
    wr(12'h010, 32'hFFFF_FFFF, 1'b0); rd(12'h010, v); chk("R3 narrow write dropped", v, 32'h0F0F_0000);
    rd(12'h010, v, 1'b0); chk("R3 narrow read zero", v, 32'h0);
    wr(12'h000, 32'h0); wr(12'h004, 32'h0); wr(12'h010, 32'h0); wr(12'h014, 32'h0);
  endtask

  task automatic t_out();
    logic [31:0] v;
    wr(12'h000, 32'hC000_0000);            // pins 0 and 1 are outputs
    wr(12'h008, 32'hFFFF_FFFF);
    chk("R5 R4 outputs driven", pin_out, 32'h0000_0003);
    cyc(2);
    rd(12'h008, v); chk("R7 inputs resampled over write", v, 32'hC000_0000);
    wr(12'h008, 32'h4000_0000);
    chk("R5 output pin follows write", pin_out, 32'h0000_0002);
    pin_in = 32'h0000_0001;                 // pin 0 high, but it is an output
    cyc(3);
    rd(12'h008, v); chk("R7 output pin ignores input", v, 32'h4000_0000);
    chk("R5 pin_out held", pin_out, 32'h0000_0002);
    pin_in = '0;
    wr(12'h000, 32'h0);
    cyc(3);
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h00C, v); chk("R6 clear all events", v, 32'h0);
    chk("R5 input-direction pin_out kept", pin_out, 32'h0000_0002);
  endtask

  task automatic t_any();
    logic [31:0] v;
    wr(12'h010, 32'hFFFF_FFFF);
    pin_in[5] = 1'b1;
    cyc(2);
    rd(12'h008, v); chk("R7 input sampled", v, 32'h0400_0000);
    rd(12'h00C, v); chk("R8 rise sets event", v, 32'h0400_0000);
    chk("R9 irq high", {31'b0, irq}, 32'h1);
    wr(12'h00C, 32'hFBFF_FFFF);
    rd(12'h00C, v); chk("R6 zero bits keep event", v, 32'h0400_0000);
    wr(12'h00C, 32'h0400_0000);
    rd(12'h00C, v); chk("R6 one clears event", v, 32'h0);
    chk("R9 irq low after clear", {31'b0, irq}, 32'h0);
    pin_in[5] = 1'b0;
    cyc(2);
    rd(12'h00C, v); chk("R8 fall sets event any-edge", v, 32'h0400_0000);
    wr(12'h00C, 32'hFFFF_FFFF);
    pin_in[31] = 1'b1;
    cyc(2);
    rd(12'h00C, v); chk("R4 pin 31 is bit 0", v, 32'h0000_0001);
    pin_in[31] = 1'b0;
    cyc(2);
    wr(12'h00C, 32'hFFFF_FFFF);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    wr(12'h014, 32'h0400_0000);
    pin_in[5] = 1'b1;
    cyc(2);
    rd(12'h008, v); chk("R7 data follows rise", v, 32'h0400_0000);
    rd(12'h00C, v); chk("R8 rise ignored falling-only", v, 32'h0);
    chk("R9 irq stays low", {31'b0, irq}, 32'h0);
    pin_in[5] = 1'b0;
    cyc(2);
    rd(12'h00C, v); chk("R8 fall sets event", v, 32'h0400_0000);
    chk("R9 irq on fall", {31'b0, irq}, 32'h1);
    wr(12'h010, 32'h0);
    chk("R9 mask drops irq", {31'b0, irq}, 32'h0);
    rd(12'h00C, v); chk("R9 event kept when masked", v, 32'h0400_0000);
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h014, 32'h0);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    wr(12'h010, 32'hFFFF_FFFF);
    pin_in[7] = 1'b1;                       // bit 24
    @(negedge clk);                         // sample registered
    wr(12'h00C, 32'h0100_0000);             // clear lands on the setting edge
    rd(12'h00C, v); chk("R10 set wins over clear", v, 32'h0100_0000);
    chk("R10 irq set", {31'b0, irq}, 32'h1);
    wr(12'h00C, 32'h0100_0000);
    rd(12'h00C, v); chk("R6 later clear works", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_out();
    t_any();
    t_fall();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule